// File: doc/BRIEF.md
# Block Sum-of-Absolute-Differences Engine

This engine measures how different two 256-entry byte arrays are, for instance two 16x16 pixel tiles from consecutive video frames. The arrays sit in two external memories that share a single address bus. Both memories return data one cycle after a read strobe. A pulse on `go` starts a pass. The controller then walks an index from 0 to 255. For each element it fetches both bytes and adds the magnitude of their difference into a 32-bit running total.

Each element takes two cycles: a loop test that issues the fetch, and an accumulate step that consumes the fetched bytes. At the end, the running total is copied into a registered result, and a one-cycle `done` pulse marks the update. The previous result stays visible while a new pass is running. The engine does not take the threshold decision that would use this result.

Top module: `sad_engine`

## Requirements
- R1: While reset is asserted and just after it is released, `sad_out` is 0, `done` is 0 and `mem_rd` is 0.
- R2: While idle and `go` is 0, the engine issues no reads (`mem_rd` stays 0) and raises no `done`.
- R3: Each pass starts from a zero total and a zero index, so a result never includes anything from an earlier pass.
- R4: The per-element term is the larger unsigned byte minus the smaller one, zero-extended to 32 bits. Swapping the contents of the two arrays gives the same result.
- R5: A pass issues exactly 256 single-cycle read strobes. `mem_addr` carries 0, 1, ..., 255 in increasing order on the strobe cycles, and the returned bytes are used in the following cycle.
- R6: `sad_out` becomes the exact sum of the 256 terms. The all-255-against-0 case gives 65280.
- R7: `done` is seen 515 clock edges (2×256+3) after the edge that samples `go` = 1 in idle.
- R8: `done` is high for exactly one cycle. It rises on the same edge that loads the new `sad_out`.
- R9: During a pass, `sad_out` keeps the previous result until the finishing edge.
- R10: A `go` pulse while a pass is running has no effect on its result or its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Start request, sampled only while idle |
| mem_addr | output | 8 | Shared element address to both memories |
| mem_rd | output | 1 | Shared read strobe; data expected next cycle |
| a_data | input | 8 | Byte returned by memory A |
| b_data | input | 8 | Byte returned by memory B |
| sad_out | output | 32 | Registered result of the last completed pass |
| done | output | 1 | One-cycle pulse when `sad_out` updates |

## Verification
A stuck or skipped controller state shows at the ports within one or two cycles as a missing or repeated read strobe, or an out-of-order address. It also shows by the end of the pass as a `done` arriving at a cycle other than 515. A total that was not cleared, or an absolute difference formed the wrong way round, shows only at the finishing edge, as a wrong `sad_out`. The stimulus therefore mixes arrays with asymmetric and swapped contents, and runs them back to back. A `go` pulse injected mid-pass would show as a changed latency or strobe count.

// File: rtl/sad_pkg.sv
package sad_pkg;
  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_INIT   = 3'd1,
    S_TEST   = 3'd2,
    S_ACC    = 3'd3,
    S_FINISH = 3'd4
  } sad_state_t;
endpackage

// File: rtl/sad_ctrl.sv
module sad_ctrl
  import sad_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       idx_lt_end,
  output sad_state_t state,
  output logic       idx_clr,
  output logic       idx_inc,
  output logic       sum_clr,
  output logic       sum_ld,
  output logic       rd_en,
  output logic       out_ld
);
  sad_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:   if (go) nxt = S_INIT;
      S_INIT:   nxt = S_TEST;
      S_TEST:   nxt = idx_lt_end ? S_ACC : S_FINISH;
      S_ACC:    nxt = S_TEST;
      S_FINISH: nxt = S_IDLE;
      default:  nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end

  assign idx_clr = (state == S_INIT);
  assign sum_clr = (state == S_INIT);
  assign idx_inc = (state == S_ACC);
  assign sum_ld  = (state == S_ACC);
  assign rd_en   = (state == S_TEST) && idx_lt_end;
  assign out_ld  = (state == S_FINISH);
endmodule

// File: rtl/sad_index.sv
module sad_index #(
  parameter int ELEMS  = 256,
  parameter int ADDR_W = $clog2(ELEMS),
  parameter int IDX_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_clr,
  input  logic              idx_inc,
  output logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr,
  output logic              idx_lt_end
);
  localparam logic [IDX_W-1:0] END_VAL = IDX_W'(ELEMS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx <= '0;
    else if (idx_clr) idx <= '0;
    else if (idx_inc) idx <= idx + 1'b1;
  end

  assign idx_lt_end = (idx < END_VAL);
  assign addr       = idx[ADDR_W-1:0];
endmodule

// File: rtl/sad_accum.sv
module sad_accum #(
  parameter int DATA_W = 8,
  parameter int SUM_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sum_clr,
  input  logic              sum_ld,
  input  logic              out_ld,
  input  logic [DATA_W-1:0] a_byte,
  input  logic [DATA_W-1:0] b_byte,
  output logic [SUM_W-1:0]  sum,
  output logic [SUM_W-1:0]  result,
  output logic              result_new
);
  function automatic logic [DATA_W-1:0] abs_diff(input logic [DATA_W-1:0] x,
                                                 input logic [DATA_W-1:0] y);
    return (x > y) ? (x - y) : (y - x);
  endfunction

  logic [SUM_W-1:0] term;
  assign term = SUM_W'(abs_diff(a_byte, b_byte));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sum <= '0;
    else if (sum_clr) sum <= '0;
    else if (sum_ld)  sum <= sum + term;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result     <= '0;
      result_new <= 1'b0;
    end else begin
      result_new <= out_ld;
      if (out_ld) result <= sum;
    end
  end
endmodule

// File: rtl/sad_engine.sv
module sad_engine
  import sad_pkg::*;
#(
  parameter int ELEMS  = 256,
  parameter int DATA_W = 8,
  parameter int SUM_W  = 32,
  localparam int ADDR_W = $clog2(ELEMS),
  localparam int IDX_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [DATA_W-1:0] a_data,
  input  logic [DATA_W-1:0] b_data,
  output logic [SUM_W-1:0]  sad_out,
  output logic              done
);
  sad_state_t       state;
  logic [IDX_W-1:0] idx;
  logic [SUM_W-1:0] sum;
  logic idx_clr, idx_inc, sum_clr, sum_ld, out_ld, idx_lt_end;

  sad_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .go(go), .idx_lt_end(idx_lt_end),
    .state(state), .idx_clr(idx_clr), .idx_inc(idx_inc),
    .sum_clr(sum_clr), .sum_ld(sum_ld), .rd_en(mem_rd), .out_ld(out_ld)
  );

  sad_index #(.ELEMS(ELEMS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_index (
    .clk(clk), .rst_n(rst_n), .idx_clr(idx_clr), .idx_inc(idx_inc),
    .idx(idx), .addr(mem_addr), .idx_lt_end(idx_lt_end)
  );

  sad_accum #(.DATA_W(DATA_W), .SUM_W(SUM_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .sum_clr(sum_clr), .sum_ld(sum_ld),
    .out_ld(out_ld), .a_byte(a_data), .b_byte(b_data),
    .sum(sum), .result(sad_out), .result_new(done)
  );
endmodule

// File: rtl/sad_engine_chk.sv
module sad_engine_chk
  import sad_pkg::*;
#(
  parameter int ELEMS  = 256,
  parameter int DATA_W = 8,
  parameter int SUM_W  = 32,
  parameter int IDX_W  = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             go,
  input logic             mem_rd,
  input logic             done,
  input logic [SUM_W-1:0] sad_out,
  input sad_state_t       state,
  input logic [IDX_W-1:0] idx,
  input logic [SUM_W-1:0] sum
);
  localparam logic [SUM_W-1:0] MAX_TERM = SUM_W'((1 << DATA_W) - 1);

  assert_idle_go_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && go) |=> (state == S_INIT));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !mem_rd);

  assert_init_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_INIT) |=> (sum == '0 && idx == '0));

  assert_term_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ACC) |=> (sum >= $past(sum) && (sum - $past(sum)) <= MAX_TERM));

  assert_fetch_then_acc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (state == S_ACC));

  assert_idx_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IDX_W'(ELEMS));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_finish_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(state) == S_FINISH && sad_out == $past(sum)));

  assert_hold_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(sad_out));

  assert_busy_ignores_go_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TEST && !(idx < IDX_W'(ELEMS))) |=> (state == S_FINISH));
endmodule

bind sad_engine sad_engine_chk #(
  .ELEMS(ELEMS), .DATA_W(DATA_W), .SUM_W(SUM_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .mem_rd(mem_rd), .done(done),
  .sad_out(sad_out), .state(state), .idx(idx), .sum(sum)
);

// File: tb/sad_engine_test.sv
module sad_engine_test;
  localparam int N   = 256;
  localparam int LAT = 2 * N + 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0;
  logic [7:0]  mem_addr;
  logic        mem_rd;
  logic [7:0]  a_data = '0;
  logic [7:0]  b_data = '0;
  logic [31:0] sad_out;
  logic        done;

  logic [7:0] mem_a [N];
  logic [7:0] mem_b [N];

  int checks = 0;
  int errors = 0;
  int rd_count = 0;
  int exp_addr = 0;
  bit addr_bad = 0;

  always #5 clk = ~clk;

  sad_engine uut (
    .clk(clk), .rst_n(rst_n), .go(go), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .a_data(a_data), .b_data(b_data), .sad_out(sad_out), .done(done)
  );

  // synchronous-read memories
  always @(posedge clk) begin
    if (mem_rd) begin
      a_data <= mem_a[mem_addr];
      b_data <= mem_b[mem_addr];
    end
  end

  // R5 strobe/address monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n && mem_rd) begin
      if (int'(mem_addr) != exp_addr) addr_bad = 1;
      exp_addr = exp_addr + 1;
      rd_count = rd_count + 1;
    end
  end

  // stimulus table: {a fill, b fill, expected sum}
  localparam logic [47:0] VEC [6] = '{
    {8'd0,   8'd0,   32'd0},
    {8'd255, 8'd0,   32'd65280},
    {8'd0,   8'd255, 32'd65280},
    {8'd100, 8'd37,  32'd16128},
    {8'd37,  8'd100, 32'd16128},
    {8'd128, 8'd127, 32'd256}
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_sad();
    int s = 0;
    for (int i = 0; i < N; i++) begin
      int d = int'(mem_a[i]) - int'(mem_b[i]);
      s += (d < 0) ? -d : d;
    end
    return s;
  endfunction

  task automatic fill_const(input logic [7:0] av, input logic [7:0] bv);
    for (int i = 0; i < N; i++) begin
      mem_a[i] = av;
      mem_b[i] = bv;
    end
  endtask

  // one pass; returns edges from go-sampling edge to done, result checked by caller
  task automatic run_pass(input bit inject_go, output int lat, output bit hold_ok);
    logic [31:0] prev;
    prev = sad_out;
    hold_ok = 1;
    rd_count = 0;
    exp_addr = 0;
    addr_bad = 0;
    @(negedge clk) go = 1'b1;
    @(posedge clk);
    @(negedge clk) go = 1'b0;
    lat = 0;
    forever begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (done) break;
      if (sad_out !== prev) hold_ok = 0;
      if (inject_go && lat == 100) go = 1'b1;
      if (inject_go && lat == 101) go = 1'b0;
      if (lat > 4 * N) break;
    end
  endtask

  task automatic pass_and_check(input int exp, input string tag, input bit inject);
    int  lat;
    bit  hold_ok;
    run_pass(inject, lat, hold_ok);
    check(sad_out == 32'(exp), tag, sad_out, exp);
    check(lat == LAT, "R7 latency", lat, LAT);
    check(hold_ok, "R9 result held", hold_ok, 1);
    check(rd_count == N && !addr_bad, "R5 strobes/addresses", rd_count, N);
    @(negedge clk);
    check(done == 1'b0, "R8 done one cycle", done, 0);
  endtask

  initial begin : watchdog
    #1900000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(sad_out == 0 && done == 0 && mem_rd == 0, "R1 in reset", sad_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(sad_out == 0 && done == 0 && mem_rd == 0, "R1 after release", sad_out, 0);

    // R2 idle without go
    rd_count = 0;
    repeat (20) @(negedge clk) if (done) checks = checks;
    check(rd_count == 0 && done == 0, "R2 idle quiet", rd_count, 0);

    // table walk; back-to-back passes exercise R3, swapped pairs R4, extremes R6
    for (int v = 0; v < 6; v++) begin
      logic [7:0]  av, bv;
      logic [31:0] ex;
      {av, bv, ex} = VEC[v];
      fill_const(av, bv);
      check(ref_sad() == int'(ex), "R4 table self", ref_sad(), ex);
      pass_and_check(int'(ex), "R6 R3 R4 table result", 1'b0);
    end

    // ramp against reversed ramp: 32768
    for (int i = 0; i < N; i++) begin
      mem_a[i] = 8'(i);
      mem_b[i] = 8'(255 - i);
    end
    pass_and_check(32768, "R6 ramp", 1'b0);

    // swapped arrays give the same total (R4)
    for (int i = 0; i < N; i++) begin
      mem_a[i] = 8'(255 - i);
      mem_b[i] = 8'(i);
    end
    pass_and_check(32768, "R4 swapped ramp", 1'b0);

    // address-dependent pattern catches misordered fetches (R5)
    for (int i = 0; i < N; i++) begin
      mem_a[i] = 8'((i * 7) % 256);
      mem_b[i] = 8'((i * 3 + 11) % 256);
    end
    pass_and_check(ref_sad(), "R5 R6 mixed pattern", 1'b0);

    // go pulse mid-pass ignored (R10)
    pass_and_check(ref_sad(), "R10 go while busy", 1'b1);

    // R2 again: after completion no further activity without go
    rd_count = 0;
    repeat (10) @(negedge clk);
    check(rd_count == 0 && done == 0, "R2 idle after pass", rd_count, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule